// File: doc/BRIEF.md
# Period Histogram Analyser

This block times the interval between consecutive rising edges of an asynchronous input signal against the fast local clock, and keeps a histogram of those intervals in on-chip memory. The input first passes through a two-stage synchronizer with a rising-edge detector. A free-running interval timer restarts on each detected edge. When the next edge arrives, the elapsed count, less a programmable start offset, picks one histogram bin. That bin is read, incremented by one and written back, and it saturates at its maximum value.

Software loads a sample total, a start offset and a repeat flag, then pulses `start`. The first edge after `start` only arms the measurement. Every later edge closes one interval. A completed interval either updates a bin or, when it falls outside the bin window, updates a saturating out-of-window counter. After the programmed number of intervals the block pulses `done`. It then either stops or, when repeat is set, starts the next pass and keeps accumulating into the same bins.

An edge that arrives while a bin update is still in flight is counted as missed and produces no bin update. A clear command zeroes every bin one address per cycle, and `busy` is held for that whole sweep. The same sweep runs on its own after reset. Bins are read back through a registered read port.

Top module: `period_hist`

## Requirements
- R1: After reset is released, `busy` is high for exactly NUM_BINS cycles while every bin is written to zero. `active`, `done`, `ovf_count` and `miss_count` read 0.
- R2: With a start offset of 0, every measured interval of P clock cycles between synchronized rising edges adds one to bin P. The first edge after `start` only arms the measurement and changes no bin or counter.
- R3: With a start offset D, an interval of P cycles is recorded in bin P−D.
- R4: An interval that is shorter than D, that gives P−D ≥ NUM_BINS, or that reaches the timer's maximum count adds one to `ovf_count` and changes no bin.
- R5: A bin that holds its maximum value (all ones) keeps that value when it is hit again.
- R6: Both bin hits and out-of-window intervals count as samples. When the count reaches `cfg_samples` (0 is treated as 1), `done` is high for one cycle. With `cfg_repeat` = 0, `active` falls in that same cycle.
- R7: With `cfg_repeat` = 1, the acquisition continues after each `done`. `done` pulses once per `cfg_samples` intervals and the bins keep accumulating.
- R8: A measuring edge that arrives within two cycles after an edge that updated a bin (the update takes three cycles) adds one to `miss_count`. It updates no bin, is not counted as a sample, and still restarts the interval timer.
- R9: A `clear` pulse accepted while `busy` is low raises `busy` from the next cycle for exactly NUM_BINS cycles. It zeroes all bins, `ovf_count` and `miss_count`, and stops the acquisition. A `start` pulse while `busy` is high is ignored.
- R10: `rd_data` returns the contents of bin `rd_addr` one cycle after the address is applied, and returns 0 for any address ≥ NUM_BINS.
- R11: `ovf_count` and `miss_count` saturate at all ones and never wrap.
- R12: Input edges while `active` is low change no bin and no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that times the intervals |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | 1 | Asynchronous signal under measurement |
| start | input | 1 | Pulse that begins an acquisition |
| clear | input | 1 | Pulse that zeroes bins and counters |
| cfg_delay | input | CNT_W | Start offset in clock cycles |
| cfg_samples | input | SAMP_W | Intervals per acquisition pass |
| cfg_repeat | input | 1 | Restart automatically after each pass |
| rd_addr | input | ADDR_W | Bin readout address |
| rd_data | output | BIN_W | Bin contents, one cycle after `rd_addr` |
| busy | output | 1 | Clear sweep in progress |
| active | output | 1 | Acquisition running |
| done | output | 1 | One-cycle pulse at the end of each pass |
| ovf_count | output | BIN_W | Out-of-window interval count |
| miss_count | output | BIN_W | Count of edges dropped during an update |

## Verification
The bench targets the edges of the bin window. It uses intervals just outside it on both sides of the offset, and an interval whose low address bits alias a valid bin. A design that wrapped instead of diverting would raise that bin rather than `ovf_count`. Intervals of two cycles drive back-to-back edges into the read-modify-write window. A design that accepted them would lose increments through a read-after-write hazard or count them as samples, and a design that did not restart the timer would record the wrong interval. Repeated hits on one bin and a long stream of missed edges show whether the bin and the counters wrap to small values instead of saturating. The clear and reset sweeps are timed cycle by cycle, so a sweep that ended one address early would leave a stale bin and a wrong `busy` length.

// File: rtl/ph_pkg.sv
// Shared types for the period histogram analyser.
// Assumes: nothing beyond IEEE 1800-2017.
package ph_pkg;
    // Classification of one synchronized rising edge by the acquisition control
    typedef enum logic [2:0] {
        EV_NONE,     // edge ignored (idle, clearing or no edge)
        EV_ARM,      // first edge of an acquisition: starts timing only
        EV_BIN,      // interval lands in the bin window
        EV_OUTSIDE,  // interval falls outside the bin window
        EV_MISS      // edge arrived while a bin update was in flight
    } ph_event_e;
endpackage

// File: rtl/ph_edge_sync.sv
// Two-flop synchronizer followed by a rising-edge detector.
// Assumes: sig_async is asynchronous to clk; rise is a one-cycle pulse and
// two pulses are always at least two cycles apart.
module ph_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_async,
    output logic rise
);
    logic [2:0] stage;

    // Shift the input through two sync flops and one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) stage <= '0;
        else        stage <= {stage[1:0], sig_async};
    end

    assign rise = stage[1] & ~stage[2];
endmodule

// File: rtl/ph_period_timer.sv
// Interval timer: restarts at 1 on each rising edge and counts up to a
// saturating maximum. At the next edge it holds the interval in cycles.
// Assumes: CNT_W is wide enough for the longest interval of interest.
module ph_period_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    output logic [CNT_W-1:0] elapsed
);
    localparam logic [CNT_W-1:0] TOP = '1;

    // Restart on an edge, otherwise count up and stick at TOP
    always_ff @(posedge clk) begin
        if (!rst_n)               elapsed <= TOP;
        else if (rise)            elapsed <= CNT_W'(1);
        else if (elapsed != TOP)  elapsed <= elapsed + CNT_W'(1);
    end
endmodule

// File: rtl/ph_acq_ctrl.sv
// Acquisition control: classifies each edge, counts samples per pass,
// handles stop/repeat, and keeps the saturating out-of-window and missed
// counters.
// Assumes: clr_go and start are single-cycle pulses; rmw_busy is high
// while a bin update is in flight.
module ph_acq_ctrl
    import ph_pkg::*;
#(
    parameter int NUM_BINS = 4000,
    parameter int CNT_W    = 16,
    parameter int SAMP_W   = 24,
    parameter int BIN_W    = 16,
    parameter int ADDR_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic [CNT_W-1:0]  elapsed,
    input  logic [CNT_W-1:0]  cfg_delay,
    input  logic [SAMP_W-1:0] cfg_samples,
    input  logic              cfg_repeat,
    input  logic              start,
    input  logic              clr_go,
    input  logic              sweeping,
    input  logic              rmw_busy,
    output ph_event_e         ev,
    output logic [ADDR_W-1:0] bin_idx,
    output logic              active,
    output logic              done,
    output logic [BIN_W-1:0]  ovf_count,
    output logic [BIN_W-1:0]  miss_count
);
    localparam logic [CNT_W-1:0]  TOP    = '1;
    localparam logic [31:0]       NB     = NUM_BINS;
    localparam logic [BIN_W-1:0]  CMAX   = '1;
    localparam logic [SAMP_W:0]   S_ONE  = (SAMP_W+1)'(1);

    logic [CNT_W-1:0]  diff;
    logic              in_win;
    logic              armed;
    logic              start_ok;
    logic [SAMP_W-1:0] samp;
    logic              pass_end;

    // Window test on the offset-corrected interval
    always_comb begin
        diff   = elapsed - cfg_delay;
        in_win = (elapsed != TOP) && (elapsed >= cfg_delay) && (32'(diff) < NB);
    end

    assign bin_idx  = diff[ADDR_W-1:0];
    assign start_ok = start && !sweeping && !clr_go;
    assign pass_end = ({1'b0, samp} + S_ONE) >= {1'b0, cfg_samples};

    // Classify the current edge; a start or clear in the same cycle wins
    always_comb begin
        ev = EV_NONE;
        if (rise && active && !sweeping && !clr_go && !start) begin
            if (!armed)        ev = EV_ARM;
            else if (rmw_busy) ev = EV_MISS;
            else if (in_win)   ev = EV_BIN;
            else               ev = EV_OUTSIDE;
        end
    end

    // Sequence the acquisition and update the counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active     <= 1'b0;
            armed      <= 1'b0;
            samp       <= '0;
            done       <= 1'b0;
            ovf_count  <= '0;
            miss_count <= '0;
        end else begin
            done <= 1'b0;
            if (clr_go) begin
                active     <= 1'b0;
                armed      <= 1'b0;
                samp       <= '0;
                ovf_count  <= '0;
                miss_count <= '0;
            end else if (start_ok) begin
                active <= 1'b1;
                armed  <= 1'b0;
                samp   <= '0;
            end else begin
                case (ev)
                    EV_ARM:  armed <= 1'b1;
                    EV_MISS: if (miss_count != CMAX) miss_count <= miss_count + BIN_W'(1);
                    EV_BIN, EV_OUTSIDE: begin
                        if (ev == EV_OUTSIDE && ovf_count != CMAX)
                            ovf_count <= ovf_count + BIN_W'(1);
                        if (pass_end) begin
                            done <= 1'b1;
                            samp <= '0;
                            if (!cfg_repeat) begin
                                active <= 1'b0;
                                armed  <= 1'b0;
                            end
                        end else begin
                            samp <= samp + SAMP_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/ph_bin_store.sv
// Histogram memory with a three-cycle read-modify-write increment
// (address, read, write-back), a sequential zeroing sweep and a registered
// readout port.
// Assumes: requests are at least three cycles apart (the control marks
// closer edges as missed), so no read-after-write forwarding is needed.
module ph_bin_store #(
    parameter int NUM_BINS = 4000,
    parameter int BIN_W    = 16,
    parameter int ADDR_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_go,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_idx,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BIN_W-1:0]  rd_data,
    output logic              sweeping,
    output logic              rmw_busy
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_BINS - 1);
    localparam logic [31:0]       NB   = NUM_BINS;
    localparam logic [BIN_W-1:0]  BMAX = '1;

    logic [BIN_W-1:0]  mem [NUM_BINS];
    logic              s1_v, s2_v;
    logic [ADDR_W-1:0] s1_a, s2_a, sw_a;
    logic [BIN_W-1:0]  s2_d;

    // Advance the update pipeline; a clear cancels anything in flight
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v <= 1'b0;
            s2_v <= 1'b0;
            s1_a <= '0;
            s2_a <= '0;
        end else begin
            s1_v <= req && !clr_go && !sweeping;
            s1_a <= req_idx;
            s2_v <= s1_v && !clr_go;
            s2_a <= s1_a;
        end
    end

    // Read stage of the increment
    always_ff @(posedge clk) begin
        if (s1_v) s2_d <= mem[s1_a];
    end

    // Walk the zeroing sweep; reset starts one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sweeping <= 1'b1;
            sw_a     <= '0;
        end else if (sweeping) begin
            if (sw_a == LAST) begin
                sweeping <= 1'b0;
                sw_a     <= '0;
            end else begin
                sw_a <= sw_a + ADDR_W'(1);
            end
        end else if (clr_go) begin
            sweeping <= 1'b1;
            sw_a     <= '0;
        end
    end

    // Single write port: sweep first, then the saturating write-back
    always_ff @(posedge clk) begin
        if (sweeping)  mem[sw_a] <= '0;
        else if (s2_v) mem[s2_a] <= (s2_d == BMAX) ? s2_d : s2_d + BIN_W'(1);
    end

    // Registered readout with zero beyond the last bin
    always_ff @(posedge clk) begin
        if (!rst_n)                 rd_data <= '0;
        else if (32'(rd_addr) < NB) rd_data <= mem[rd_addr];
        else                        rd_data <= '0;
    end

    assign rmw_busy = s1_v | s2_v;
endmodule

// File: rtl/period_hist.sv
// Period histogram analyser top: synchronizer, interval timer, acquisition
// control and histogram store.
// Assumes: configuration inputs are held steady while an acquisition runs.
module period_hist
    import ph_pkg::*;
#(
    parameter int NUM_BINS = 4000,
    parameter int BIN_W    = 16,
    parameter int CNT_W    = 16,
    parameter int SAMP_W   = 24,
    localparam int ADDR_W  = $clog2(NUM_BINS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sig_in,
    input  logic              start,
    input  logic              clear,
    input  logic [CNT_W-1:0]  cfg_delay,
    input  logic [SAMP_W-1:0] cfg_samples,
    input  logic              cfg_repeat,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BIN_W-1:0]  rd_data,
    output logic              busy,
    output logic              active,
    output logic              done,
    output logic [BIN_W-1:0]  ovf_count,
    output logic [BIN_W-1:0]  miss_count
);
    logic              rise;
    logic [CNT_W-1:0]  elapsed;
    ph_event_e         ev;
    logic [ADDR_W-1:0] bin_idx;
    logic              rmw_busy;
    logic              clr_go;
    logic              bin_req;

    assign clr_go  = clear & ~busy;
    assign bin_req = (ev == EV_BIN);

    ph_edge_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_async (sig_in),
        .rise      (rise)
    );

    ph_period_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise    (rise),
        .elapsed (elapsed)
    );

    ph_acq_ctrl #(
        .NUM_BINS (NUM_BINS),
        .CNT_W    (CNT_W),
        .SAMP_W   (SAMP_W),
        .BIN_W    (BIN_W),
        .ADDR_W   (ADDR_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise        (rise),
        .elapsed     (elapsed),
        .cfg_delay   (cfg_delay),
        .cfg_samples (cfg_samples),
        .cfg_repeat  (cfg_repeat),
        .start       (start),
        .clr_go      (clr_go),
        .sweeping    (busy),
        .rmw_busy    (rmw_busy),
        .ev          (ev),
        .bin_idx     (bin_idx),
        .active      (active),
        .done        (done),
        .ovf_count   (ovf_count),
        .miss_count  (miss_count)
    );

    ph_bin_store #(
        .NUM_BINS (NUM_BINS),
        .BIN_W    (BIN_W),
        .ADDR_W   (ADDR_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_go   (clr_go),
        .req      (bin_req),
        .req_idx  (bin_idx),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .sweeping (busy),
        .rmw_busy (rmw_busy)
    );
endmodule

// File: rtl/period_hist_chk.sv
// Port-level temporal checks for period_hist, attached by bind.
// Assumes: the same parameter values as the bound instance.
module period_hist_chk #(
    parameter int NUM_BINS = 4000,
    parameter int BIN_W    = 16,
    parameter int ADDR_W   = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              cfg_repeat,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [BIN_W-1:0]  rd_data,
    input logic              busy,
    input logic              active,
    input logic              done,
    input logic [BIN_W-1:0]  ovf_count,
    input logic [BIN_W-1:0]  miss_count
);
    localparam logic [31:0] NB = NUM_BINS;

    AST_SWEEP_HALTS_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !active); // R9

    AST_SWEEP_NOT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_STOP_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(cfg_repeat) && !$past(start)) |-> !active); // R6

    AST_OVF_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ovf_count >= $past(ovf_count))); // R11

    AST_MISS_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (miss_count >= $past(miss_count))); // R11

    AST_READ_BEYOND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(rd_addr) >= NB) |=> (rd_data == '0)); // R10

    AST_IDLE_COUNTERS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !busy && !$past(active) && !$past(busy))
        |-> ($stable(ovf_count) && $stable(miss_count))); // R12
endmodule

bind period_hist period_hist_chk #(
    .NUM_BINS (NUM_BINS),
    .BIN_W    (BIN_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cfg_repeat (cfg_repeat),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .busy       (busy),
    .active     (active),
    .done       (done),
    .ovf_count  (ovf_count),
    .miss_count (miss_count)
);

// File: tb/period_hist_test.sv
`timescale 1ns/1ps
// Self-checking bench for period_hist with small parameters.
module period_hist_test;
    localparam int NB = 60;
    localparam int BW = 4;
    localparam int CW = 10;
    localparam int SW = 8;
    localparam int AW = $clog2(NB);

    typedef struct packed {
        int dly; int per; int nmeas; int bin; int exp_bin; int exp_ovf;
    } row_t;

    // Walked by one loop: offset, interval, intervals, bin read, bin value, ovf
    localparam row_t ROWS [7] = '{
        '{0,  5,   3, 5,  3,  0},   // R2 short interval
        '{0,  20,  4, 20, 4,  0},   // R2 longer interval
        '{3,  10,  2, 7,  2,  0},   // R3 offset shifts the bin
        '{10, 6,   3, 6,  0,  3},   // R4 interval below offset
        '{0,  70,  2, 6,  0,  2},   // R4 beyond last bin, aliases bin 6
        '{40, 95,  2, 55, 2,  0},   // R3 large offset
        '{0,  8,  20, 8,  15, 0}    // R5 bin saturates at 15
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sig_in = 1'b0;
    logic          start = 1'b0;
    logic          clear = 1'b0;
    logic [CW-1:0] cfg_delay = '0;
    logic [SW-1:0] cfg_samples = '0;
    logic          cfg_repeat = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [BW-1:0] rd_data;
    logic          busy, active, done;
    logic [BW-1:0] ovf_count, miss_count;

    int n_tests = 0;
    int n_fail  = 0;
    int done_seen = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    period_hist #(.NUM_BINS(NB), .BIN_W(BW), .CNT_W(CW), .SAMP_W(SW)) uut (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .start(start), .clear(clear),
        .cfg_delay(cfg_delay), .cfg_samples(cfg_samples), .cfg_repeat(cfg_repeat),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .active(active),
        .done(done), .ovf_count(ovf_count), .miss_count(miss_count)
    );

    always @(negedge clk) if (rst_n && done === 1'b1) done_seen++;

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_train(input int per, input int edges);
        int hi = per / 2;
        int lo = per - hi;
        for (int e = 0; e < edges; e++) begin
            sig_in = 1'b1; repeat (hi) @(negedge clk);
            sig_in = 1'b0; repeat (lo) @(negedge clk);
        end
    endtask

    task automatic count_busy(output int cnt);
        cnt = 0;
        while (busy === 1'b1 && cnt < 1000) begin cnt++; @(negedge clk); end
    endtask

    task automatic do_clear(output int cnt);
        clear = 1'b1; @(negedge clk); clear = 1'b0;
        count_busy(cnt);
    endtask

    task automatic do_start();
        start = 1'b1; @(negedge clk); start = 1'b0;
    endtask

    task automatic read_bin(input int a, output logic [31:0] v);
        rd_addr = AW'(a); @(negedge clk); v = 32'(rd_data);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int cnt;
        logic [31:0] v;
        wait_n(5);
        rst_n = 1'b1;
        #0.5;
        // R1 reset state
        check("R1 active after reset", active, 0);
        check("R1 done after reset", done, 0);
        check("R1 ovf after reset", ovf_count, 0);
        check("R1 miss after reset", miss_count, 0);
        count_busy(cnt);
        check("R1 reset sweep length", cnt, NB);
        read_bin(0, v);      check("R1 bin 0 zero", v, 0);
        read_bin(NB - 1, v); check("R1 last bin zero", v, 0);

        // Table: R2 R3 R4 R5 with R6 stop behaviour on every row
        for (int i = 0; i < 7; i++) begin
            row_t r;
            r = ROWS[i];
            do_clear(cnt);
            cfg_delay = CW'(r.dly);
            cfg_samples = SW'(r.nmeas);
            cfg_repeat = 1'b0;
            done_seen = 0;
            do_start();
            pulse_train(r.per, r.nmeas + 1);
            wait_n(8);
            read_bin(r.bin, v);
            check($sformatf("R2/R3/R5 row %0d bin value", i), v, r.exp_bin);
            check($sformatf("R4 row %0d ovf_count", i), ovf_count, r.exp_ovf);
            check($sformatf("R6 row %0d done pulses", i), done_seen, 1);
            check($sformatf("R6 row %0d stopped", i), active, 0);
        end

        // R7 repeat: 6 intervals at 2 per pass
        do_clear(cnt);
        cfg_delay = '0; cfg_samples = SW'(2); cfg_repeat = 1'b1;
        done_seen = 0;
        do_start();
        pulse_train(9, 7);
        wait_n(8);
        check("R7 done per pass", done_seen, 3);
        check("R7 still active", active, 1);
        read_bin(9, v); check("R7 bins accumulate", v, 6);
        cfg_repeat = 1'b0;

        // R8 missed edges at a 2-cycle interval
        do_clear(cnt);
        check("R9 clear stops acquisition", active, 0);
        cfg_delay = '0; cfg_samples = SW'(200);
        do_start();
        pulse_train(2, 7);
        wait_n(8);
        check("R8 miss count", miss_count, 3);
        read_bin(2, v); check("R8 accepted edges only", v, 3);
        check("R8 misses not samples", active, 1);

        // R11 counter saturation, R5 bin saturation on the same stream
        pulse_train(2, 40);
        wait_n(8);
        check("R11 miss_count saturates", miss_count, 15);
        read_bin(2, v); check("R5 bin saturates", v, 15);

        // R9 clear zeroes everything
        do_clear(cnt);
        check("R9 clear sweep length", cnt, NB);
        check("R9 miss cleared", miss_count, 0);
        check("R9 ovf cleared", ovf_count, 0);
        read_bin(2, v); check("R9 bin cleared", v, 0);

        // R12 edges ignored while idle
        pulse_train(5, 5);
        wait_n(8);
        read_bin(5, v); check("R12 idle bin untouched", v, 0);
        check("R12 idle ovf untouched", ovf_count, 0);
        check("R12 idle miss untouched", miss_count, 0);

        // R9 start during sweep is ignored
        clear = 1'b1; @(negedge clk); clear = 1'b0;
        start = 1'b1; @(negedge clk); start = 1'b0;
        count_busy(cnt);
        check("R9 start ignored while busy", active, 0);

        // R10 readout beyond last bin returns zero
        read_bin(NB + 2, v); check("R10 read beyond last bin", v, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule